// File: doc/BRIEF.md
# In-Group Store/Load Overlap Detector

This block sits beside an instruction group tracker. It keeps the stores issued in the current dispatch group and checks each later load in the same group against them. When the load may touch bytes that one of those stores wrote, the block raises a conflict flag. The group tracker turns that flag into a no-op hazard, which keeps the load out of the group.

Addresses are never computed. Each access is described by two symbolic operands. The base is a register tag. The first operand is either a register tag used as an index or a constant offset, and a flag tells which. Each store entry holds these two operands and a size code. A load gives the same operands and its own size code. Every valid entry is compared with the load in parallel, and the conflict output is the OR of the per-entry hits. A pulse on the group-end input empties the table.

The table occupancy is controlled by a state machine with three states. OCC_EMPTY holds no entries. OCC_PARTIAL holds at least one entry and has space left. OCC_FULL has every entry in use. The transitions are:
- store_first: OCC_EMPTY to OCC_PARTIAL, or straight to OCC_FULL when the depth is one.
- store_more: OCC_PARTIAL stays in OCC_PARTIAL.
- store_last: OCC_PARTIAL to OCC_FULL when the last free entry is written.
- store_drop: OCC_FULL stays in OCC_FULL and sets the drop flag.
- group_clear: any state to OCC_EMPTY.

Top module: `grp_alias_detect`

## Requirements
- R1: After reset the table is empty, `conflict_o` is 0 for any load, and `store_drop_o` is 0.
- R2: The size code maps to a byte count as follows: 0 is 1 byte, 1 is 2, 2 is 4, 3 is 8 and 4 is 16. Codes 5 to 7 are treated as 16 bytes.
- R3: A load whose base, first-operand constant flag and first operand all equal those of a recorded store gives `conflict_o` = 1.
- R4: Both first operands may be register tags (flag 0). If the load's base equals the store's first operand and the load's first operand equals the store's base, `conflict_o` = 1.
- R5: Bases equal, both first operands constant, and the store offset below the load offset: `conflict_o` = 1 exactly when store offset + store bytes > load offset. The sum is computed without wrap.
- R6: Bases equal, both first operands constant, and the store offset at or above the load offset: `conflict_o` = 1 exactly when load offset + load bytes > store offset.
- R7: `conflict_o` is 0 in each of these cases:
  - `ld_valid_i` is 0;
  - no store has been recorded in the current group;
  - the operands fit none of the cases in R3 to R6 (different bases, different tags, or a constant against a register tag).
- R8: A `grp_end_i` pulse discards every recorded store from the next cycle on. A store given in the same cycle as `grp_end_i` is also discarded.
- R9: The table holds DEPTH (default 4) stores. A store that arrives while the table is full is ignored, and `store_drop_o` rises on the next cycle. It then stays high until a group end.
- R10: All entries are checked in parallel, so a load that matches any one of them conflicts. A store becomes visible to loads from the cycle after it is given, never in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_end_i | input | 1 | Dispatch group end pulse; clears the table |
| st_valid_i | input | 1 | A store is issued this cycle |
| st_size_i | input | SZ_W | Store size code |
| st_base_i | input | OPD_W | Store base register tag |
| st_first_const_i | input | 1 | Store first operand is a constant offset |
| st_first_i | input | OPD_W | Store offset or index tag |
| ld_valid_i | input | 1 | A load is checked this cycle |
| ld_size_i | input | SZ_W | Load size code |
| ld_base_i | input | OPD_W | Load base register tag |
| ld_first_const_i | input | 1 | Load first operand is a constant offset |
| ld_first_i | input | OPD_W | Load offset or index tag |
| conflict_o | output | 1 | Load overlaps a recorded store (combinational) |
| store_drop_o | output | 1 | A store was dropped because the table was full (sticky until group end) |

## Verification
The assertions check these properties on every cycle:
- No conflict is reported in the cycle after a group end, or before any store in the group.
- A load that exactly repeats the operands of the store accepted one cycle earlier always conflicts.
- The drop flag rises on an overflow store, clears on group end, and holds its value otherwise.

Only the bench scenarios can show the following:
- The byte-range arithmetic, including touching ranges, 16-byte accesses, reserved size codes and sums beyond the offset width.
- The commuted-operand match.
- That a dropped store really leaves no trace in the table.

// File: rtl/grp_alias_pkg.sv
package grp_alias_pkg;

    // Occupancy of the in-group store table
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Largest size code that has its own byte count; larger codes saturate
    localparam int SZ_CODE_MAX = 4;

    // Width of a byte count able to hold 2**SZ_CODE_MAX
    localparam int BYTES_W = SZ_CODE_MAX + 1;

endpackage

// File: rtl/alias_size_dec.sv
module alias_size_dec
    import grp_alias_pkg::*;
#(
    parameter int SZ_W = 3
) (
    input  logic [SZ_W-1:0]    code_i,
    output logic [BYTES_W-1:0] bytes_o
);

    localparam logic [SZ_W-1:0] CODE_SAT = SZ_W'(SZ_CODE_MAX);

    always_comb begin
        if (code_i >= CODE_SAT) begin
            bytes_o = BYTES_W'(1) << SZ_CODE_MAX;
        end else begin
            bytes_o = BYTES_W'(1) << code_i;
        end
    end

endmodule

// File: rtl/alias_occ_fsm.sv
module alias_occ_fsm
    import grp_alias_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             st_i,
    output logic [DEPTH-1:0] wr_sel_o,
    output logic             full_o,
    output logic             drop_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEPTH);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             drop_q, drop_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            drop_q  <= drop_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        drop_d  = clr_i ? 1'b0 : drop_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (!clr_i && st_i) begin          // store_first
                    cnt_d   = CNT_W'(1);
                    state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end
            end
            OCC_PARTIAL: begin
                if (clr_i) begin                   // group_clear
                    state_d = OCC_EMPTY;
                    cnt_d   = '0;
                end else if (st_i) begin           // store_more / store_last
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_d == CNT_TOP) begin
                        state_d = OCC_FULL;
                    end
                end
            end
            OCC_FULL: begin
                if (clr_i) begin                   // group_clear
                    state_d = OCC_EMPTY;
                    cnt_d   = '0;
                end else if (st_i) begin           // store_drop
                    drop_d = 1'b1;
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        wr_sel_o = '0;
        full_o   = (state_q == OCC_FULL);
        drop_o   = drop_q;
        if (st_i && !clr_i && (state_q != OCC_FULL)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_q == CNT_W'(i)) begin
                    wr_sel_o[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/alias_entry.sv
module alias_entry
    import grp_alias_pkg::*;
#(
    parameter int OPD_W = 8,
    parameter int SZ_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_i,
    input  logic [SZ_W-1:0]    st_size_i,
    input  logic [OPD_W-1:0]   st_base_i,
    input  logic               st_fc_i,
    input  logic [OPD_W-1:0]   st_first_i,
    input  logic [OPD_W-1:0]   ld_base_i,
    input  logic               ld_fc_i,
    input  logic [OPD_W-1:0]   ld_first_i,
    input  logic [BYTES_W-1:0] ld_bytes_i,
    output logic               hit_o
);

    localparam int SUM_W = ((OPD_W > BYTES_W) ? OPD_W : BYTES_W) + 1;

    logic               vld_q;
    logic [SZ_W-1:0]    size_q;
    logic [OPD_W-1:0]   base_q;
    logic               fc_q;
    logic [OPD_W-1:0]   first_q;

    logic [BYTES_W-1:0] st_bytes;
    logic               same_base;
    logic               exact_m;
    logic               swap_m;
    logic               range_m;
    logic [SUM_W-1:0]   st_lo, ld_lo, st_end, ld_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            size_q  <= '0;
            base_q  <= '0;
            fc_q    <= 1'b0;
            first_q <= '0;
        end else if (clr_i) begin
            vld_q <= 1'b0;
        end else if (wr_i) begin
            vld_q   <= 1'b1;
            size_q  <= st_size_i;
            base_q  <= st_base_i;
            fc_q    <= st_fc_i;
            first_q <= st_first_i;
        end
    end

    alias_size_dec #(.SZ_W(SZ_W)) u_sdec (
        .code_i  (size_q),
        .bytes_o (st_bytes)
    );

    always_comb begin
        same_base = (base_q == ld_base_i);
        exact_m   = same_base && (fc_q == ld_fc_i) && (first_q == ld_first_i);
        swap_m    = !fc_q && !ld_fc_i &&
                    (first_q == ld_base_i) && (ld_first_i == base_q);
        st_lo     = SUM_W'(first_q);
        ld_lo     = SUM_W'(ld_first_i);
        st_end    = st_lo + SUM_W'(st_bytes);
        ld_end    = ld_lo + SUM_W'(ld_bytes_i);
        range_m   = 1'b0;
        if (same_base && fc_q && ld_fc_i) begin
            if (st_lo < ld_lo) begin
                range_m = (st_end > ld_lo);
            end else begin
                range_m = (ld_end > st_lo);
            end
        end
        hit_o = vld_q && (exact_m || swap_m || range_m);
    end

endmodule

// File: rtl/grp_alias_detect.sv
module grp_alias_detect
    import grp_alias_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OPD_W = 8,
    parameter int SZ_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_end_i,
    input  logic             st_valid_i,
    input  logic [SZ_W-1:0]  st_size_i,
    input  logic [OPD_W-1:0] st_base_i,
    input  logic             st_first_const_i,
    input  logic [OPD_W-1:0] st_first_i,
    input  logic             ld_valid_i,
    input  logic [SZ_W-1:0]  ld_size_i,
    input  logic [OPD_W-1:0] ld_base_i,
    input  logic             ld_first_const_i,
    input  logic [OPD_W-1:0] ld_first_i,
    output logic             conflict_o,
    output logic             store_drop_o
);

    logic [DEPTH-1:0]   wr_sel;
    logic [DEPTH-1:0]   hits;
    logic [BYTES_W-1:0] ld_bytes;
    logic               occ_full;

    alias_occ_fsm #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (grp_end_i),
        .st_i     (st_valid_i),
        .wr_sel_o (wr_sel),
        .full_o   (occ_full),
        .drop_o   (store_drop_o)
    );

    alias_size_dec #(.SZ_W(SZ_W)) u_ldec (
        .code_i  (ld_size_i),
        .bytes_o (ld_bytes)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        alias_entry #(.OPD_W(OPD_W), .SZ_W(SZ_W)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (grp_end_i),
            .wr_i       (wr_sel[g]),
            .st_size_i  (st_size_i),
            .st_base_i  (st_base_i),
            .st_fc_i    (st_first_const_i),
            .st_first_i (st_first_i),
            .ld_base_i  (ld_base_i),
            .ld_fc_i    (ld_first_const_i),
            .ld_first_i (ld_first_i),
            .ld_bytes_i (ld_bytes),
            .hit_o      (hits[g])
        );
    end

    assign conflict_o = ld_valid_i && (|hits);

endmodule

// File: rtl/alias_checker.sv
module alias_checker #(
    parameter int OPD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_end_i,
    input logic             st_valid_i,
    input logic [OPD_W-1:0] st_base_i,
    input logic             st_first_const_i,
    input logic [OPD_W-1:0] st_first_i,
    input logic             ld_valid_i,
    input logic [OPD_W-1:0] ld_base_i,
    input logic             ld_first_const_i,
    input logic [OPD_W-1:0] ld_first_i,
    input logic             occ_full,
    input logic             conflict_o,
    input logic             store_drop_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (grp_end_i) begin
            seen_q <= 1'b0;
        end else if (st_valid_i) begin
            seen_q <= 1'b1;
        end
    end

    // R8: nothing survives a group end
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_i |=> !conflict_o);

    // R7: conflicts need a live load and a store in this group
    assert_needs_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (seen_q && ld_valid_i));

    // R3: exact repeat of the store accepted one cycle earlier
    assert_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && $past(rst_n) &&
         $past(st_valid_i && !grp_end_i && !occ_full) &&
         (ld_base_i == $past(st_base_i)) &&
         (ld_first_const_i == $past(st_first_const_i)) &&
         (ld_first_i == $past(st_first_i))) |-> conflict_o);

    // R9: overflow store raises the drop flag
    assert_drop_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && occ_full && !grp_end_i) |=> store_drop_o);

    // R9: drop flag cleared by a group end
    assert_drop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_i |=> !store_drop_o);

    // R9: drop flag holds without a store or group end
    assert_drop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_end_i && !st_valid_i) |=> $stable(store_drop_o));

endmodule

bind grp_alias_detect alias_checker #(.OPD_W(OPD_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .grp_end_i        (grp_end_i),
    .st_valid_i       (st_valid_i),
    .st_base_i        (st_base_i),
    .st_first_const_i (st_first_const_i),
    .st_first_i       (st_first_i),
    .ld_valid_i       (ld_valid_i),
    .ld_base_i        (ld_base_i),
    .ld_first_const_i (ld_first_const_i),
    .ld_first_i       (ld_first_i),
    .occ_full         (occ_full),
    .conflict_o       (conflict_o),
    .store_drop_o     (store_drop_o)
);

// File: tb/grp_alias_detect_test.sv
module grp_alias_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int OPD_W = 8;
    localparam int SZ_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grp_end_i = 1'b0;
    logic             st_valid_i = 1'b0;
    logic [SZ_W-1:0]  st_size_i = '0;
    logic [OPD_W-1:0] st_base_i = '0;
    logic             st_first_const_i = 1'b0;
    logic [OPD_W-1:0] st_first_i = '0;
    logic             ld_valid_i = 1'b0;
    logic [SZ_W-1:0]  ld_size_i = '0;
    logic [OPD_W-1:0] ld_base_i = '0;
    logic             ld_first_const_i = 1'b0;
    logic [OPD_W-1:0] ld_first_i = '0;
    logic             conflict_o;
    logic             store_drop_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_alias_detect #(.DEPTH(4), .OPD_W(OPD_W), .SZ_W(SZ_W)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .grp_end_i        (grp_end_i),
        .st_valid_i       (st_valid_i),
        .st_size_i        (st_size_i),
        .st_base_i        (st_base_i),
        .st_first_const_i (st_first_const_i),
        .st_first_i       (st_first_i),
        .ld_valid_i       (ld_valid_i),
        .ld_size_i        (ld_size_i),
        .ld_base_i        (ld_base_i),
        .ld_first_const_i (ld_first_const_i),
        .ld_first_i       (ld_first_i),
        .conflict_o       (conflict_o),
        .store_drop_o     (store_drop_o)
    );

    typedef struct packed {
        logic [2:0] s_sz;
        logic [7:0] s_base;
        logic       s_fc;
        logic [7:0] s_first;
        logic [2:0] l_sz;
        logic [7:0] l_base;
        logic       l_fc;
        logic [7:0] l_first;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 8'h05, 1'b0, 8'h09, 3'd2, 8'h05, 1'b0, 8'h09, 1'b1, 4'd3},  // R3 exact tags
        '{3'd2, 8'h05, 1'b0, 8'h09, 3'd2, 8'h09, 1'b0, 8'h05, 1'b1, 4'd4},  // R4 commuted
        '{3'd2, 8'h05, 1'b0, 8'h09, 3'd2, 8'h05, 1'b0, 8'h0A, 1'b0, 4'd7},  // R7 other index
        '{3'd2, 8'h05, 1'b1, 8'd8,  3'd0, 8'h05, 1'b1, 8'd11,  1'b1, 4'd5}, // R5 overlap
        '{3'd2, 8'h05, 1'b1, 8'd8,  3'd0, 8'h05, 1'b1, 8'd12,  1'b0, 4'd5}, // R5 touching
        '{3'd0, 8'h05, 1'b1, 8'd20, 3'd3, 8'h05, 1'b1, 8'd16,  1'b1, 4'd6}, // R6 overlap
        '{3'd0, 8'h05, 1'b1, 8'd24, 3'd3, 8'h05, 1'b1, 8'd16,  1'b0, 4'd6}, // R6 touching
        '{3'd0, 8'h05, 1'b1, 8'd7,  3'd0, 8'h05, 1'b1, 8'd7,   1'b1, 4'd6}, // R6 equal offsets
        '{3'd4, 8'h05, 1'b1, 8'd0,  3'd0, 8'h05, 1'b1, 8'd15,  1'b1, 4'd2}, // R2 16 bytes
        '{3'd4, 8'h05, 1'b1, 8'd0,  3'd0, 8'h05, 1'b1, 8'd16,  1'b0, 4'd2}, // R2 16 bytes edge
        '{3'd7, 8'h05, 1'b1, 8'd0,  3'd0, 8'h05, 1'b1, 8'd15,  1'b1, 4'd2}, // R2 reserved code
        '{3'd2, 8'h05, 1'b1, 8'd9,  3'd2, 8'h05, 1'b0, 8'd9,   1'b0, 4'd7}, // R7 const vs tag
        '{3'd2, 8'h05, 1'b1, 8'd8,  3'd2, 8'h06, 1'b1, 8'd8,   1'b0, 4'd7}, // R7 other base
        '{3'd3, 8'h05, 1'b1, 8'd250, 3'd0, 8'h05, 1'b1, 8'd255, 1'b1, 4'd5} // R5 no wrap
    };

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        grp_end_i  = 1'b0;
        st_valid_i = 1'b0;
        ld_valid_i = 1'b0;
    endtask

    task automatic set_store(input logic [2:0] sz, input logic [7:0] b,
                             input logic fc, input logic [7:0] f);
        st_valid_i = 1'b1; st_size_i = sz; st_base_i = b;
        st_first_const_i = fc; st_first_i = f;
    endtask

    task automatic set_load(input logic [2:0] sz, input logic [7:0] b,
                            input logic fc, input logic [7:0] f);
        ld_valid_i = 1'b1; ld_size_i = sz; ld_base_i = b;
        ld_first_const_i = fc; ld_first_i = f;
    endtask

    task automatic end_group();
        @(negedge clk);
        idle_inputs();
        grp_end_i = 1'b1;
        @(negedge clk);
        grp_end_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        set_load(3'd2, 8'h05, 1'b0, 8'h09);
        #1;
        chk(conflict_o, 1'b0, "R1 conflict after reset");
        chk(store_drop_o, 1'b0, "R1 drop flag after reset");
        idle_inputs();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            end_group();
            set_store(VECS[i].s_sz, VECS[i].s_base, VECS[i].s_fc, VECS[i].s_first);
            @(negedge clk);
            idle_inputs();
            set_load(VECS[i].l_sz, VECS[i].l_base, VECS[i].l_fc, VECS[i].l_first);
            #1;
            chk(conflict_o, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
            ld_valid_i = 1'b0;
        end

        // R7: a matching entry but no load valid
        end_group();
        set_store(3'd2, 8'h05, 1'b0, 8'h09);
        @(negedge clk);
        idle_inputs();
        ld_base_i = 8'h05; ld_first_const_i = 1'b0; ld_first_i = 8'h09;
        #1;
        chk(conflict_o, 1'b0, "R7 load not valid");

        // R8: store given together with group end is discarded
        end_group();
        @(negedge clk);
        grp_end_i = 1'b1;
        set_store(3'd2, 8'h05, 1'b0, 8'h09);
        @(negedge clk);
        idle_inputs();
        set_load(3'd2, 8'h05, 1'b0, 8'h09);
        #1;
        chk(conflict_o, 1'b0, "R8 store with group end");
        idle_inputs();

        // R10: same-cycle store is not visible, next cycle it is
        end_group();
        set_store(3'd2, 8'h33, 1'b0, 8'h44);
        set_load(3'd2, 8'h33, 1'b0, 8'h44);
        #1;
        chk(conflict_o, 1'b0, "R10 same-cycle store hidden");
        @(negedge clk);
        st_valid_i = 1'b0;
        #1;
        chk(conflict_o, 1'b1, "R10 store visible next cycle");
        idle_inputs();

        // R9/R10: fill four entries, then overflow
        end_group();
        for (int k = 0; k < 4; k++) begin
            set_store(3'd2, 8'(8'h10 + k), 1'b0, 8'h20);
            @(negedge clk);
        end
        idle_inputs();
        #1;
        chk(store_drop_o, 1'b0, "R9 no drop with table just full");
        set_store(3'd2, 8'h14, 1'b0, 8'h20);
        @(negedge clk);
        idle_inputs();
        #1;
        chk(store_drop_o, 1'b1, "R9 drop flag after overflow store");
        set_load(3'd2, 8'h14, 1'b0, 8'h20);
        #1;
        chk(conflict_o, 1'b0, "R9 overflow store ignored");
        ld_base_i = 8'h13;
        #1;
        chk(conflict_o, 1'b1, "R10 last entry hit");
        ld_base_i = 8'h10;
        #1;
        chk(conflict_o, 1'b1, "R10 first entry hit");
        ld_base_i = 8'h20; ld_first_i = 8'h11;
        #1;
        chk(conflict_o, 1'b1, "R4 commuted hit on second entry");
        idle_inputs();
        repeat (3) @(negedge clk);
        #1;
        chk(store_drop_o, 1'b1, "R9 drop flag sticky");

        // R8: group end clears table and drop flag
        end_group();
        #1;
        chk(store_drop_o, 1'b0, "R8 drop flag cleared");
        set_load(3'd2, 8'h10, 1'b0, 8'h20);
        #1;
        chk(conflict_o, 1'b0, "R8 entries cleared");
        idle_inputs();

        // R7: no store in group
        set_load(3'd0, 8'h05, 1'b1, 8'd0);
        #1;
        chk(conflict_o, 1'b0, "R7 no stores recorded");
        idle_inputs();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule